// File: doc/BRIEF.md
# Four-Way Set-Associative Read Cache with Age-Rank Replacement

This block is a read cache placed between a requester and a word-wide backing memory. A request carries a 32-bit byte address. The address is split into three fields: the low two bits are ignored, the next eight bits select one of 256 sets, and the top 22 bits form the tag. The four ways of the selected set are compared at the same time. A match returns that way's stored word one cycle after the request is accepted.

When no way matches, the cache stalls the requester and issues one word read to the backing memory. It writes the returned word into a victim way of the set, and then answers with that word. The victim is picked as follows:

- If the set has an empty way, the lowest-numbered empty way is used.
- Otherwise, the way least recently touched is evicted.

Recency is kept per set as a 2-bit age rank for each way. A hit or a fill makes the touched way the youngest. Each way that was younger than it gets one step older.

Top module: `lru4_cache`

## Requirements
- R1: After reset, every line is empty, so the first access to any address misses. With no traffic, `req_ready` is 1 and `mem_rd` and `rsp_valid` are 0.
- R2: Address bits [1:0] have no effect on lookup. Bits [9:2] select the set and bits [31:10] are the tag, so addresses that differ only in bits [1:0] hit the same line.
- R3: A hit is answered in the cycle after acceptance. In that cycle `rsp_valid`=1, `rsp_filled`=0 and `rsp_data` holds the stored word, and no memory read is issued.
- R4: A miss raises `mem_rd` in the cycle after acceptance, with `mem_addr` equal to the request address with bits [1:0] cleared. Both are held until `mem_valid` is seen.
- R5: In the cycle after `mem_valid`, `rsp_valid`=1, `rsp_filled`=1 and `rsp_data` equals the word returned by memory. `req_ready` is 1 again in that cycle.
- R6: `req_ready` is 0 from an accepted miss until its response. A request presented while `req_ready` is 0 is ignored: it causes no memory read and installs nothing.
- R7: While the indexed set holds an empty way, a fill goes to the lowest-numbered empty way, so four different tags in one set all stay resident.
- R8: With all four ways valid, a miss evicts the way whose last hit or fill is the oldest. The touched way becomes the youngest, and each way that was younger than it ages by one.
- R9: Hits and fills in one set leave the contents and age order of every other set unchanged.
- R10: At most one way matches a lookup, and the returned word comes from that matching way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_addr | input | 32 | Byte address of the request |
| req_ready | output | 1 | Cache can accept a request this cycle |
| rsp_valid | output | 1 | Response word valid (one cycle) |
| rsp_filled | output | 1 | Response came from a memory fill rather than a hit |
| rsp_data | output | 32 | Response word |
| mem_rd | output | 1 | Word read request to backing memory |
| mem_addr | output | 32 | Word-aligned read address |
| mem_valid | input | 1 | Backing memory returns the word this cycle |
| mem_data | input | 32 | Word returned by backing memory |

## Verification
The hardest state to reach from the ports is a full set whose age order is mixed, because only then can eviction of the true oldest way be told apart from simpler rules such as round-robin or oldest fill. The stimulus first fills one set with four tags. It then re-touches them in an order unlike their fill order, and checks which tags survive each new miss. A miss in a neighbouring set is placed in the middle of that sequence to show that it leaves the order undisturbed. A stray request held during a fill shows that the stall drops it.

// File: rtl/cache_pkg.sv
package cache_pkg;

    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int WAYS   = 4;
    localparam int SETS   = 256;
    localparam int OFF_W  = 2;
    localparam int IDX_W  = $clog2(SETS);
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
    localparam int WAY_W  = $clog2(WAYS);

    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [WAY_W-1:0]  way_t;
    typedef logic [DATA_W-1:0] data_t;
    typedef logic [WAYS-1:0][WAY_W-1:0] ranks_t;

    typedef struct packed {
        tag_t             tag;
        idx_t             idx;
        logic [OFF_W-1:0] off;
    } addr_t;

    typedef enum logic {ST_IDLE, ST_FILL} state_e;

    // Make way w youngest; every way younger than it ages by one.
    function automatic ranks_t promote(ranks_t r, way_t w);
        ranks_t n;
        for (int i = 0; i < WAYS; i++) begin
            if (way_t'(i) == w)     n[i] = '0;
            else if (r[i] < r[w])   n[i] = r[i] + 1'b1;
            else                    n[i] = r[i];
        end
        return n;
    endfunction

    // Lowest empty way wins; otherwise the way holding the oldest rank.
    function automatic way_t pick_victim(logic [WAYS-1:0] vld, ranks_t r);
        way_t v;
        v = '0;
        for (int i = 0; i < WAYS; i++)
            if (r[i] == way_t'(WAYS - 1)) v = way_t'(i);
        for (int i = WAYS - 1; i >= 0; i--)
            if (!vld[i]) v = way_t'(i);
        return v;
    endfunction

endpackage

// File: rtl/cache_way.sv
module cache_way
    import cache_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  idx_t  lk_idx,
    input  tag_t  lk_tag,
    input  logic  wr_en,
    input  data_t wr_data,
    output logic  match,
    output logic  vld,
    output data_t rd_data
);

    logic [SETS-1:0] valid_q;
    tag_t            tag_q  [SETS];
    data_t           data_q [SETS];

    always_ff @(posedge clk) begin
        if (rst)        valid_q         <= '0;
        else if (wr_en) valid_q[lk_idx] <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[lk_idx]  <= lk_tag;
            data_q[lk_idx] <= wr_data;
        end
    end

    always_comb begin
        vld     = valid_q[lk_idx];
        match   = vld && (tag_q[lk_idx] == lk_tag);
        rd_data = data_q[lk_idx];
    end

endmodule

// File: rtl/cache_lru.sv
module cache_lru
    import cache_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  idx_t            lk_idx,
    input  logic [WAYS-1:0] vld_vec,
    input  logic            upd_en,
    input  way_t            upd_way,
    output way_t            victim
);

    ranks_t rank_q [SETS];
    ranks_t cur;
    logic [WAYS-1:0] seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++)
                    rank_q[s][w] <= way_t'(w);
        end else if (upd_en) begin
            rank_q[lk_idx] <= promote(rank_q[lk_idx], upd_way);
        end
    end

    always_comb begin
        cur    = rank_q[lk_idx];
        victim = pick_victim(vld_vec, cur);
        seen   = '0;
        for (int w = 0; w < WAYS; w++) seen[cur[w]] = 1'b1;
    end

    // R8
    rank_perm_chk: assert property (@(posedge clk) disable iff (rst)
        &seen);

    // R8
    touched_young_chk: assert property (@(posedge clk) disable iff (rst)
        upd_en |=> rank_q[$past(lk_idx)][$past(upd_way)] == '0);

endmodule

// File: rtl/cache_ctrl.sv
module cache_ctrl
    import cache_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  req_valid,
    input  addr_t req_addr,
    input  logic  any_hit,
    input  data_t hit_data,
    input  way_t  victim,
    input  logic  mem_valid,
    input  data_t mem_data,
    output logic  req_ready,
    output logic  accept,
    output addr_t lk_addr,
    output logic  fill_we,
    output way_t  fill_way,
    output logic  mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    output logic  rsp_valid,
    output logic  rsp_filled,
    output data_t rsp_data
);

    state_e state_q;
    addr_t  req_q;
    way_t   vict_q;

    always_comb begin
        req_ready = !rst && (state_q == ST_IDLE);
        accept    = req_valid && req_ready;
        lk_addr   = (state_q == ST_FILL) ? req_q : req_addr;
        fill_we   = (state_q == ST_FILL) && mem_valid;
        fill_way  = vict_q;
        mem_addr  = {req_q.tag, req_q.idx, {OFF_W{1'b0}}};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            mem_rd     <= 1'b0;
            rsp_valid  <= 1'b0;
            rsp_filled <= 1'b0;
            rsp_data   <= '0;
            req_q      <= '0;
            vict_q     <= '0;
        end else begin
            rsp_valid <= 1'b0;
            case (state_q)
                ST_IDLE: if (accept) begin
                    if (any_hit) begin
                        rsp_valid  <= 1'b1;
                        rsp_filled <= 1'b0;
                        rsp_data   <= hit_data;
                    end else begin
                        state_q <= ST_FILL;
                        req_q   <= req_addr;
                        vict_q  <= victim;
                        mem_rd  <= 1'b1;
                    end
                end
                ST_FILL: if (mem_valid) begin
                    state_q    <= ST_IDLE;
                    mem_rd     <= 1'b0;
                    rsp_valid  <= 1'b1;
                    rsp_filled <= 1'b1;
                    rsp_data   <= mem_data;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R3
    hit_resp_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && any_hit) |=> (rsp_valid && !rsp_filled && !mem_rd));

    // R4
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_rd && !mem_valid) |=> (mem_rd && $stable(mem_addr)));

    // R5
    fill_resp_chk: assert property (@(posedge clk) disable iff (rst)
        fill_we |=> (rsp_valid && rsp_filled && req_ready));

    // R6
    stall_chk: assert property (@(posedge clk) disable iff (rst)
        mem_rd |-> !req_ready);

endmodule

// File: rtl/lru4_cache.sv
module lru4_cache
    import cache_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic [31:0] req_addr,
    output logic        req_ready,
    output logic        rsp_valid,
    output logic        rsp_filled,
    output logic [31:0] rsp_data,
    output logic        mem_rd,
    output logic [31:0] mem_addr,
    input  logic        mem_valid,
    input  logic [31:0] mem_data
);

    addr_t           lk_addr;
    logic [WAYS-1:0] match_vec;
    logic [WAYS-1:0] vld_vec;
    data_t           way_data [WAYS];
    logic            any_hit;
    way_t            hit_way;
    data_t           hit_data;
    way_t            victim;
    logic            accept;
    logic            fill_we;
    way_t            fill_way;
    logic            upd_en;
    way_t            upd_way;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        cache_way u_way (
            .clk     (clk),
            .rst     (rst),
            .lk_idx  (lk_addr.idx),
            .lk_tag  (lk_addr.tag),
            .wr_en   (fill_we && (fill_way == way_t'(w))),
            .wr_data (mem_data),
            .match   (match_vec[w]),
            .vld     (vld_vec[w]),
            .rd_data (way_data[w])
        );
    end

    always_comb begin
        any_hit  = |match_vec;
        hit_way  = '0;
        for (int w = 0; w < WAYS; w++)
            if (match_vec[w]) hit_way = way_t'(w);
        hit_data = way_data[hit_way];
        upd_en   = (accept && any_hit) || fill_we;
        upd_way  = fill_we ? fill_way : hit_way;
    end

    cache_lru u_lru (
        .clk     (clk),
        .rst     (rst),
        .lk_idx  (lk_addr.idx),
        .vld_vec (vld_vec),
        .upd_en  (upd_en),
        .upd_way (upd_way),
        .victim  (victim)
    );

    cache_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_addr   (req_addr),
        .any_hit    (any_hit),
        .hit_data   (hit_data),
        .victim     (victim),
        .mem_valid  (mem_valid),
        .mem_data   (mem_data),
        .req_ready  (req_ready),
        .accept     (accept),
        .lk_addr    (lk_addr),
        .fill_we    (fill_we),
        .fill_way   (fill_way),
        .mem_rd     (mem_rd),
        .mem_addr   (mem_addr),
        .rsp_valid  (rsp_valid),
        .rsp_filled (rsp_filled),
        .rsp_data   (rsp_data)
    );

    // R10
    one_match_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(match_vec));

    // R7
    empty_first_chk: assert property (@(posedge clk) disable iff (rst)
        (fill_we && !(&vld_vec)) |-> !vld_vec[fill_way]);

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        $past(rst) |-> (!mem_rd && !rsp_valid));

endmodule

// File: tb/lru4_cache_bench.sv
module lru4_cache_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_ready;
    logic        rsp_valid;
    logic        rsp_filled;
    logic [31:0] rsp_data;
    logic        mem_rd;
    logic [31:0] mem_addr;
    logic        mem_valid = 1'b0;
    logic [31:0] mem_data = '0;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    lru4_cache u_lru4_cache (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_filled(rsp_filled),
        .rsp_data(rsp_data), .mem_rd(mem_rd), .mem_addr(mem_addr),
        .mem_valid(mem_valid), .mem_data(mem_data)
    );

    function automatic logic [31:0] memval(input logic [31:0] a);
        return ~{a[15:0], a[31:16]} ^ 32'h1357_9BDF;
    endfunction

    task automatic check(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    typedef struct packed {
        logic [31:0] a;
        logic        fill;
        logic [3:0]  rq;
    } vec_t;

    // set 5 tags A..F, one line in set 6
    localparam logic [31:0] A = {22'h3C0011, 8'd5, 2'b00};
    localparam logic [31:0] B = {22'h000022, 8'd5, 2'b00};
    localparam logic [31:0] C = {22'h2A0033, 8'd5, 2'b00};
    localparam logic [31:0] D = {22'h150044, 8'd5, 2'b00};
    localparam logic [31:0] E = {22'h3FFFFF, 8'd5, 2'b00};
    localparam logic [31:0] F = {22'h000022, 8'd6, 2'b00};

    // R7: A..D fill empty ways; R10: each way returns its own word
    // R8: age order decides eviction; R9: set 6 traffic leaves set 5 order alone
    // R2: A+3 hits A's line
    localparam vec_t VEC [21] = '{
        '{A, 1'b1, 4'd7}, '{B, 1'b1, 4'd7}, '{C, 1'b1, 4'd7}, '{D, 1'b1, 4'd7},
        '{A, 1'b0, 4'd10}, '{B, 1'b0, 4'd10}, '{C, 1'b0, 4'd10}, '{D, 1'b0, 4'd10},
        '{C, 1'b0, 4'd3}, '{A, 1'b0, 4'd3},
        '{E, 1'b1, 4'd8}, '{F, 1'b1, 4'd9}, '{A, 1'b0, 4'd8},
        '{B, 1'b1, 4'd8}, '{C, 1'b0, 4'd9}, '{D, 1'b1, 4'd8},
        '{A, 1'b0, 4'd8}, '{E, 1'b1, 4'd8}, '{A + 32'd3, 1'b0, 4'd2},
        '{B, 1'b1, 4'd8}, '{D, 1'b0, 4'd8}
    };

    task automatic access(input logic [31:0] a, input bit exp_fill, input string rq,
                          input bit intrude);
        bit got;
        bit rd_seen;
        int wait_n;
        int lat;
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        @(negedge clk);
        req_valid = 1'b0;
        got = 0; rd_seen = 0; wait_n = 0; lat = 0;
        for (int c = 0; c < 20 && !got; c++) begin
            mem_valid = 1'b0;
            if (rsp_valid) begin
                got = 1;
                lat = c;
            end else if (mem_rd) begin
                if (!rd_seen) begin
                    rd_seen = 1;
                    // R4: aligned read address
                    check(mem_addr == {a[31:2], 2'b00}, "R4 mem_addr", mem_addr, {a[31:2], 2'b00});
                end
                if (intrude) begin
                    // R6: stalled, stray request presented
                    check(req_ready == 1'b0, "R6 ready during fill", 32'(req_ready), 32'd0);
                    req_valid = 1'b1;
                    req_addr  = a ^ 32'h0001_0000;
                end
                if (wait_n == 2) begin
                    req_valid = 1'b0;
                    mem_valid = 1'b1;
                    mem_data  = memval(mem_addr);
                end else begin
                    wait_n++;
                end
            end
            if (!got) @(negedge clk);
        end
        mem_valid = 1'b0;
        req_valid = 1'b0;
        check(got, {rq, " response seen"}, 32'(got), 32'd1);
        check(rsp_filled == exp_fill, {rq, " hit/fill kind"}, 32'(rsp_filled), 32'(exp_fill));
        check(rsp_data == memval({a[31:2], 2'b00}), {rq, " data"}, rsp_data, memval({a[31:2], 2'b00}));
        if (exp_fill) begin
            // R5: answer one cycle after mem_valid, ready restored
            check(lat == 3 && req_ready, {rq, " R5 fill timing"}, 32'(lat), 32'd3);
        end else begin
            // R3: hit answered the cycle after acceptance, no read issued
            check(lat == 0 && !rd_seen, {rq, " R3 hit timing"}, 32'(lat), 32'd0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: idle state after reset
        check(req_ready == 1'b1, "R1 ready", 32'(req_ready), 32'd1);
        check(mem_rd == 1'b0, "R1 mem_rd", 32'(mem_rd), 32'd0);
        check(rsp_valid == 1'b0, "R1 rsp_valid", 32'(rsp_valid), 32'd0);

        for (int i = 0; i < 21; i++)
            access(VEC[i].a, VEC[i].fill, $sformatf("R%0d vec%0d", VEC[i].rq, i), 1'b0);

        // R6: stray request during a fill is dropped
        access({22'h012345, 8'd7, 2'b00}, 1'b1, "R6 stalled miss", 1'b1);
        access({22'h012345, 8'd7, 2'b00} ^ 32'h0001_0000, 1'b1, "R6 stray not installed", 1'b0);

        // R1: reset empties the cache again
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        access(A, 1'b1, "R1 miss after reset", 1'b0);
        access(A, 1'b0, "R1 hit after refill", 1'b0);

        done = 1;
    end

    initial begin
        for (int n = 0; n < 20000 && !done; n++) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule